// File: doc/BRIEF.md
# Configurable-Latency Booth Wallace-Tree Multiplier

The block multiplies a signed two's complement multiplicand by a signed two's complement multiplier and returns the full-width signed product. The multiplier is recoded into radix-4 digits in the range -2..+2. Each digit selects zero, the multiplicand, twice the multiplicand, or the negation of one of these, shifted to its digit weight. The resulting matrix of partial-product rows goes through a chain of carry-save steps. Each step compresses every group of three rows into a sum row and a carry row, shifting the carries left by one place, until two rows remain. One carry-propagate adder then sums those two rows.

Two parameters set the timing. `LAT_STEPS` is the number of clock cycles spent in the carry-save tree. At 0 the tree is purely combinational. At 1 the complete tree runs in one cycle and a register captures its output. Above 1, fewer step stages are built. Their output rows are registered and sent back through the same stages until the `LAT_STEPS` passes are done. Surplus steps only see two rows or zero rows, so they leave the sum unchanged. `ADD_LAT` (0 or 1) chooses between a combinational final adder and a registered one. A one-cycle `start_i` pulse launches a calculation. A one-cycle `ready_o` pulse marks the cycle in which `product_o` is valid.

Top module: `wt_booth_mul`

## Requirements
- R1: When `ready_o` is high, `product_o` (A_W+B_W bits, two's complement) equals the signed product of the two operands taken at the accepted start. This holds for the most negative operand values and for odd multiplier widths.
- R2: With a total latency `LAT_STEPS+ADD_LAT` greater than 0, `ready_o` is high for exactly one cycle. That cycle comes exactly `LAT_STEPS+ADD_LAT` clock cycles after the cycle in which the start was accepted.
- R3: Operands are captured in the cycle `start_i` is accepted. Changing `mcand_i` or `mplier_i` afterwards does not change the pending result.
- R4: With `LAT_STEPS` of 1 or more, a `start_i` pulse in any of the `LAT_STEPS` cycles after an accepted start is ignored. It produces no extra ready pulse, and the pending result still belongs to the first operands.
- R5: With `LAT_STEPS=0` and `ADD_LAT=0` the block is combinational. `ready_o` equals `start_i` in the same cycle, and `product_o` follows the current operands.
- R6: With `LAT_STEPS=0` and `ADD_LAT=1`, starts in consecutive cycles are each accepted. Each start produces a ready pulse one cycle later, carrying that start's product.
- R7: With `ADD_LAT=1`, `product_o` keeps its value in every cycle without a ready pulse and changes only when a new result is presented.
- R8: After reset `ready_o` is low, and a registered product output reads zero.
- R9: A result is still exact when the required number of reduction steps is not a multiple of the stages per pass, so that extra steps run on an already reduced matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that launches a calculation |
| mcand_i | input | A_W | Signed multiplicand |
| mplier_i | input | B_W | Signed multiplier |
| ready_o | output | 1 | One-cycle pulse: product valid |
| product_o | output | A_W+B_W | Signed product |

## Verification
The bench targets the extreme operands (most negative times most negative, zero, minus one) and an odd multiplier width. A wrong sign extension of the recoded digits, or a dropped carry shift, would give wrong products exactly there. The default build needs three reduction steps but runs four over two passes. A feedback register that lost or misplaced rows would therefore corrupt the product on an extra pass. The bench fires a second start in the middle of a calculation and changes the operands after each start. A design that re-launched or failed to capture would then show an extra ready pulse or a product built from the new operands. Back-to-back starts on the registered-adder build and same-cycle ready on the combinational build expose off-by-one ready timing.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

  // rows in the Booth matrix, padded to at least two
  function automatic int booth_rows(int bw);
    int n;
    n = (bw + 1) / 2;
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int step_rows(int r);
    return 2 * (r / 3) + (r % 3);
  endfunction

  function automatic int rows_after(int r0, int k);
    int r;
    r = r0;
    for (int i = 0; i < k; i++) r = step_rows(r);
    return r;
  endfunction

  function automatic int steps_to_two(int r0);
    int r;
    int s;
    r = r0;
    s = 0;
    for (int i = 0; i < 64; i++) begin
      if (r > 2) begin
        r = step_rows(r);
        s++;
      end
    end
    return s;
  endfunction

  // step stages built in hardware for a given tree latency
  function automatic int stages_built(int n_steps, int lat);
    int s;
    if (lat <= 1) return n_steps;
    s = (n_steps + lat - 1) / lat;
    return (s < 1) ? 1 : s;
  endfunction

endpackage

// File: rtl/wtm_booth_pp.sv
module wtm_booth_pp #(
  parameter int A_W    = 12,
  parameter int B_W    = 9,
  parameter int N_ROWS = 5
) (
  input  logic [A_W-1:0]                      mcand_i,
  input  logic [B_W-1:0]                      mplier_i,
  output logic [N_ROWS-1:0][A_W+B_W-1:0]      rows_o
);
  localparam int P_W = A_W + B_W;
  localparam int ND  = (B_W + 1) / 2;
  localparam int BE  = 2 * ND;

  logic [BE:0]    bx;
  logic [P_W-1:0] a_ext;

  assign bx    = {BE'($signed(mplier_i)), 1'b0};
  assign a_ext = P_W'($signed(mcand_i));

  always_comb begin
    logic [P_W-1:0] pp;
    rows_o = '0;
    for (int i = 0; i < ND; i++) begin
      case (bx[2*i +: 3])
        3'b001, 3'b010: pp = a_ext;
        3'b011:         pp = a_ext << 1;
        3'b100:         pp = -(a_ext << 1);
        3'b101, 3'b110: pp = -a_ext;
        default:        pp = '0;
      endcase
      rows_o[i] = pp << (2 * i);
    end
  end

endmodule

// File: rtl/wtm_csa.sv
module wtm_csa #(
  parameter int P_W = 21
) (
  input  logic [P_W-1:0] x_i,
  input  logic [P_W-1:0] y_i,
  input  logic [P_W-1:0] z_i,
  output logic [P_W-1:0] sum_o,
  output logic [P_W-1:0] cry_o
);
  logic [P_W-1:0] maj;

  assign sum_o = x_i ^ y_i ^ z_i;
  assign maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  assign cry_o = {maj[P_W-2:0], 1'b0};

  wire unused_top = maj[P_W-1];

endmodule

// File: rtl/wtm_step.sv
module wtm_step #(
  parameter int P_W   = 21,
  parameter int N_MAX = 5,
  parameter int N_IN  = 5
) (
  input  logic [N_MAX-1:0][P_W-1:0] rows_i,
  output logic [N_MAX-1:0][P_W-1:0] rows_o
);
  localparam int NG    = N_IN / 3;
  localparam int NL    = N_IN % 3;
  localparam int N_OUT = 2 * NG + NL;

  for (genvar g = 0; g < NG; g++) begin : g_csa
    wtm_csa #(.P_W(P_W)) u_csa (
      .x_i  (rows_i[3*g]),
      .y_i  (rows_i[3*g+1]),
      .z_i  (rows_i[3*g+2]),
      .sum_o(rows_o[2*g]),
      .cry_o(rows_o[2*g+1])
    );
  end

  for (genvar j = 0; j < NL; j++) begin : g_pass
    assign rows_o[2*NG+j] = rows_i[3*NG+j];
  end

  for (genvar j = N_OUT; j < N_MAX; j++) begin : g_zero
    assign rows_o[j] = '0;
  end

  // rows above N_IN are zero by construction of the matrix
  wire unused_rows = ^rows_i;

endmodule

// File: rtl/wtm_ctrl.sv
module wtm_ctrl #(
  parameter int LAT_STEPS = 2,
  parameter int ADD_LAT   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_first_o,
  output logic load_next_o,
  output logic tree_done_o,
  output logic ready_o
);
  wire unused_clk = clk_i ^ rst_ni;

  if (LAT_STEPS == 0) begin : g_comb_tree
    assign load_first_o = 1'b0;
    assign load_next_o  = 1'b0;
    assign tree_done_o  = start_i;
  end else begin : g_iter_tree
    localparam int CW = $clog2(LAT_STEPS + 1);
    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign load_first_o = start_i && !busy_q;
    assign load_next_o  = busy_q && (cnt_q < CW'(LAT_STEPS));
    assign tree_done_o  = busy_q && (cnt_q == CW'(LAT_STEPS));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (load_first_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
      end else if (load_next_o) begin
        cnt_q  <= cnt_q + CW'(1);
      end else if (tree_done_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  if (ADD_LAT == 0) begin : g_ready_comb
    assign ready_o = tree_done_o;
  end else begin : g_ready_reg
    logic ready_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ready_q <= 1'b0;
      else         ready_q <= tree_done_o;
    end
    assign ready_o = ready_q;
  end

endmodule

// File: rtl/wt_booth_mul.sv
module wt_booth_mul #(
  parameter int A_W       = 12,
  parameter int B_W       = 9,
  parameter int LAT_STEPS = 2,
  parameter int ADD_LAT   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [A_W-1:0]     mcand_i,
  input  logic [B_W-1:0]     mplier_i,
  output logic               ready_o,
  output logic [A_W+B_W-1:0] product_o
);
  import wtm_pkg::*;

  localparam int P_W     = A_W + B_W;
  localparam int N_ROWS  = booth_rows(B_W);
  localparam int N_STEPS = steps_to_two(N_ROWS);
  localparam int N_STG   = stages_built(N_STEPS, LAT_STEPS);

  logic [N_ROWS-1:0][P_W-1:0] pp_rows;
  logic [N_ROWS-1:0][P_W-1:0] tree_in;
  logic [N_STG:0][N_ROWS-1:0][P_W-1:0] chain;
  logic [P_W-1:0] fin0, fin1, sum;
  logic load_first, load_next, tree_done;

  wtm_booth_pp #(.A_W(A_W), .B_W(B_W), .N_ROWS(N_ROWS)) u_pp (
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .rows_o  (pp_rows)
  );

  wtm_ctrl #(.LAT_STEPS(LAT_STEPS), .ADD_LAT(ADD_LAT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .load_first_o(load_first),
    .load_next_o (load_next),
    .tree_done_o (tree_done),
    .ready_o     (ready_o)
  );

  assign chain[0] = tree_in;

  // stage k is sized for the fullest matrix it can see (first pass)
  for (genvar k = 0; k < N_STG; k++) begin : g_stage
    wtm_step #(
      .P_W  (P_W),
      .N_MAX(N_ROWS),
      .N_IN (rows_after(N_ROWS, k))
    ) u_step (
      .rows_i(chain[k]),
      .rows_o(chain[k+1])
    );
  end

  if (LAT_STEPS == 0) begin : g_tree_comb
    assign tree_in = pp_rows;
    assign fin0    = chain[N_STG][0];
    assign fin1    = chain[N_STG][1];
    wire unused_ld    = load_first ^ load_next;
    wire unused_chain = ^chain[N_STG];
  end else begin : g_tree_iter
    logic [N_ROWS-1:0][P_W-1:0] fb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       fb_q <= '0;
      else if (load_first || load_next) fb_q <= chain[N_STG];
    end
    assign tree_in = load_first ? pp_rows : fb_q;
    assign fin0    = fb_q[0];
    assign fin1    = fb_q[1];
  end

  assign sum = fin0 + fin1;

  if (ADD_LAT == 0) begin : g_add_comb
    assign product_o = sum;
  end else begin : g_add_reg
    logic [P_W-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        prod_q <= '0;
      else if (tree_done) prod_q <= sum;
    end
    assign product_o = prod_q;
  end

endmodule

// File: rtl/wt_booth_mul_chk.sv
module wt_booth_mul_chk #(
  parameter int A_W       = 12,
  parameter int B_W       = 9,
  parameter int LAT_STEPS = 2,
  parameter int ADD_LAT   = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [A_W-1:0]     mcand_i,
  input logic [B_W-1:0]     mplier_i,
  input logic               ready_o,
  input logic [A_W+B_W-1:0] product_o
);
  localparam int P_W = A_W + B_W;
  localparam int TOT = LAT_STEPS + ADD_LAT;

  logic [P_W-1:0] exp_now;
  assign exp_now = $signed({{B_W{mcand_i[A_W-1]}}, mcand_i}) *
                   $signed({{A_W{mplier_i[B_W-1]}}, mplier_i});

  if (TOT == 0) begin : g_c0
    assert_comb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o == start_i) && (product_o == exp_now));
  end else if (LAT_STEPS == 0) begin : g_c1
    assert_b2b_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o == $past(start_i));
    assert_b2b_product_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> product_o == $past(exp_now));
  end else begin : g_cn
    logic           busy_s;
    int             cnt_s;
    logic [P_W-1:0] exp_s;
    logic           acc;

    // shadow of start acceptance; a start during the tree passes is dropped (R4)
    assign acc = start_i && (!busy_s || cnt_s > LAT_STEPS);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_s <= 1'b0;
        cnt_s  <= 0;
        exp_s  <= '0;
      end else if (acc) begin
        busy_s <= 1'b1;
        cnt_s  <= 1;
        exp_s  <= exp_now;
      end else if (busy_s) begin
        if (cnt_s == TOT) busy_s <= 1'b0;
        else              cnt_s  <= cnt_s + 1;
      end
    end

    assert_ready_timing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o == (busy_s && cnt_s == TOT));
    assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |=> !ready_o);
    assert_product_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> product_o == exp_s);
    if (ADD_LAT == 1) begin : g_hold
      assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> $stable(product_o));
    end
  end

endmodule

bind wt_booth_mul wt_booth_mul_chk #(
  .A_W(A_W), .B_W(B_W), .LAT_STEPS(LAT_STEPS), .ADD_LAT(ADD_LAT)
) u_chk (.*);

// File: tb/wt_booth_mul_bench.sv
`timescale 1ns/1ps
module wt_booth_mul_bench;

  localparam int TOT = 3;  // default build: LAT_STEPS=2, ADD_LAT=1

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  // default build 12x9
  logic        a_start = 1'b0;
  logic [11:0] a_mc = '0;
  logic [8:0]  a_mp = '0;
  logic        a_rdy;
  logic [20:0] a_prod;
  // combinational build 8x8
  logic        c_start = 1'b0;
  logic [7:0]  c_mc = '0;
  logic [7:0]  c_mp = '0;
  logic        c_rdy;
  logic [15:0] c_prod;
  // registered-adder-only build 10x5
  logic        p_start = 1'b0;
  logic [9:0]  p_mc = '0;
  logic [4:0]  p_mp = '0;
  logic        p_rdy;
  logic [14:0] p_prod;

  wt_booth_mul u_wt_booth_mul (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(a_start), .mcand_i(a_mc),
    .mplier_i(a_mp), .ready_o(a_rdy), .product_o(a_prod));

  wt_booth_mul #(.A_W(8), .B_W(8), .LAT_STEPS(0), .ADD_LAT(0)) u_wt_booth_mul_c (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(c_start), .mcand_i(c_mc),
    .mplier_i(c_mp), .ready_o(c_rdy), .product_o(c_prod));

  wt_booth_mul #(.A_W(10), .B_W(5), .LAT_STEPS(0), .ADD_LAT(1)) u_wt_booth_mul_p (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(p_start), .mcand_i(p_mc),
    .mplier_i(p_mp), .ready_o(p_rdy), .product_o(p_prod));

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  int a_prev = 0;

  function automatic int sx(int v, int w);
    return (v <<< (32 - w)) >>> (32 - w);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic a_op(int x, int y, bit intrude);
    int exp;
    string req;
    req = intrude ? "R4 start ignored" : "R1 R9 product";
    @(negedge clk);
    a_start = 1'b1;
    a_mc = x[11:0];
    a_mp = y[8:0];
    exp = sx(x, 12) * sx(y, 9);
    for (int k = 1; k <= TOT + 1; k++) begin
      @(negedge clk);
      chk(a_rdy == (k == TOT), "R2 ready timing", int'(a_rdy), int'(k == TOT));
      if (k < TOT)
        chk(sx(int'(a_prod), 21) == a_prev, "R7 hold", sx(int'(a_prod), 21), a_prev);
      if (k == TOT) begin
        chk(sx(int'(a_prod), 21) == exp, req, sx(int'(a_prod), 21), exp);
        a_prev = exp;
      end
      // R3: operands change right after capture
      a_start = (k == 1) ? intrude : 1'b0;
      a_mc = 12'($urandom());
      a_mp = 9'($urandom());
    end
  endtask

  task automatic c_op(int x, int y);
    int exp;
    @(negedge clk);
    c_start = 1'b1;
    c_mc = x[7:0];
    c_mp = y[7:0];
    exp = sx(x, 8) * sx(y, 8);
    #1;
    chk(c_rdy == 1'b1, "R5 ready same cycle", int'(c_rdy), 1);
    chk(sx(int'(c_prod), 16) == exp, "R1 R5 product", sx(int'(c_prod), 16), exp);
    @(negedge clk);
    c_start = 1'b0;
    c_mc = 8'($urandom());
    exp = sx(int'(c_mc), 8) * sx(y, 8);
    #1;
    chk(c_rdy == 1'b0, "R5 ready low", int'(c_rdy), 0);
    chk(sx(int'(c_prod), 16) == exp, "R5 follows operands", sx(int'(c_prod), 16), exp);
  endtask

  task automatic p_burst(int n);
    int pexp;
    @(negedge clk);
    p_start = 1'b1;
    p_mc = 10'($urandom());
    p_mp = 5'($urandom());
    pexp = sx(int'(p_mc), 10) * sx(int'(p_mp), 5);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      chk(p_rdy == 1'b1, "R6 back-to-back ready", int'(p_rdy), 1);
      chk(sx(int'(p_prod), 15) == pexp, "R1 R6 product", sx(int'(p_prod), 15), pexp);
      if (i < n) begin
        if (i == 1) begin p_mc = 10'h200; p_mp = 5'h10; end
        else begin p_mc = 10'($urandom()); p_mp = 5'($urandom()); end
        pexp = sx(int'(p_mc), 10) * sx(int'(p_mp), 5);
      end else begin
        p_start = 1'b0;
      end
    end
    @(negedge clk);
    chk(p_rdy == 1'b0, "R6 ready drops", int'(p_rdy), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(a_rdy == 1'b0, "R8 reset ready", int'(a_rdy), 0);
    chk(a_prod == '0, "R8 reset product", int'(a_prod), 0);
    chk(p_rdy == 1'b0, "R8 reset ready p", int'(p_rdy), 0);
    chk(p_prod == '0, "R8 reset product p", int'(p_prod), 0);

    a_op(-2048, -256, 1'b0);
    a_op(2047, 255, 1'b0);
    a_op(-2048, 255, 1'b0);
    a_op(0, -77, 1'b0);
    a_op(-1, -1, 1'b0);
    a_op(1, -256, 1'b1);
    a_op(-1234, 171, 1'b1);
    for (int i = 0; i < 40; i++)
      a_op(int'($urandom() & 32'hfff), int'($urandom() & 32'h1ff), i[2]);

    c_op(-128, -128);
    c_op(127, -128);
    c_op(0, 0);
    for (int i = 0; i < 30; i++)
      c_op(int'($urandom() & 32'hff), int'($urandom() & 32'hff));

    p_burst(4);
    p_burst(20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule